// File: doc/BRIEF.md
# Connection Memory Bulk Initializer

This block fills every location of a switching connection memory with one preset value, so software does not have to write each location after power up. Software first sets an enable bit, which arms the block when it goes from low to high. It then writes a start bit together with a 3-bit pattern. The block waits for the next frame boundary. It then owns the memory write port and writes the value `{zeros, pattern}` to every address, one address per clock cycle. The fill lasts exactly two full frames.

When the second frame boundary arrives, the start bit clears itself. The enable bit stays set until software clears it. A new fill needs another low-to-high edge on the enable bit. A configuration write that clears either bit before the fill completes stops it at once. Locations not yet reached keep their old contents. While the start bit is set, host writes to the memory are discarded. Host reads go through the normal port at all times.

Top module: `cm_bulk_init`

## Requirements
- R1: After reset, stat_enable, stat_start and stat_busy are all 0.
- R2: A configuration write with cfg_enable=1 and cfg_start=1 sets stat_start only if stat_enable was already 1 and had risen from 0 since the last completed fill. A start request while enable is low leaves stat_start at 0, and host writes still take effect.
- R3: After a completed fill, a further start request with enable still high is ignored until enable is written 0 and then 1 again.
- R4: After a start, the fill begins at the next frame_sync pulse. stat_busy is high from the cycle after that pulse through the cycle of the second following pulse, which is exactly two frames of cycles.
- R5: A completed fill leaves every location equal to the pattern in bits 2..0 and zero in bits 15..3.
- R6: At fill completion stat_start returns to 0 on its own, and stat_enable remains 1.
- R7: A configuration write with cfg_start=0 or cfg_enable=0 during a fill aborts it in that cycle. Locations whose turn had not come keep their previous value. stat_start and stat_busy are 0 on the next cycle.
- R8: While stat_start is 1, a host write (cm_we) is discarded. Otherwise it stores cm_wdata at cm_addr.
- R9: cm_rdata presents the contents of cm_addr one clock cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | One-cycle pulse at each frame boundary |
| cfg_we | input | 1 | Write strobe for the configuration fields |
| cfg_enable | input | 1 | Enable (arm) bit written on cfg_we |
| cfg_start | input | 1 | Start bit written on cfg_we |
| cfg_pattern | input | 3 | Pattern written on cfg_we |
| stat_enable | output | 1 | Current enable bit |
| stat_start | output | 1 | Current start bit, set until fill ends or aborts |
| stat_busy | output | 1 | High while the sequencer is in its fill frames |
| cm_we | input | 1 | Host memory write strobe |
| cm_addr | input | ADDR_W | Host memory address for read and write |
| cm_wdata | input | DATA_W | Host memory write data |
| cm_rdata | output | DATA_W | Registered read data |

## Verification
The host write path and the sequencer can both ask for the memory port in the same cycle. The bench provokes this by issuing a host write to an address the fill has already passed. The write is judged correct only if that location still reads back the pattern. An abort write can also land in the same cycle as a sequencer write. The bench places the abort a known number of cycles after busy rises. It then expects exactly that many leading locations to hold the pattern and every later location to hold its preloaded value.

// File: rtl/cmi_pkg.sv
package cmi_pkg;
    localparam int PAT_W = 3;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_FILL
    } seq_state_e;

    typedef struct packed {
        logic             en;
        logic             start;
        logic             armed;
        logic [PAT_W-1:0] pat;
    } cfg_state_t;
endpackage

// File: rtl/cmi_ctrl.sv
module cmi_ctrl
    import cmi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_enable,
    input  logic             cfg_start,
    input  logic [PAT_W-1:0] cfg_pattern,
    input  logic             fill_done,
    output logic             en_o,
    output logic             start_o,
    output logic             armed_o,
    output logic [PAT_W-1:0] pat_o,
    output logic             abort_o
);
    cfg_state_t cfg_d, cfg_q;
    logic       abort_d;

    always_comb begin
        cfg_d   = cfg_q;
        abort_d = 1'b0;
        if (cfg_we) begin
            cfg_d.en  = cfg_enable;
            cfg_d.pat = cfg_pattern;
            if (!cfg_enable) begin
                cfg_d.armed = 1'b0;
            end else if (!cfg_q.en) begin
                cfg_d.armed = 1'b1;
            end
            if (!cfg_enable || !cfg_start) begin
                cfg_d.start = 1'b0;
                abort_d     = cfg_q.start;
            end else if (!cfg_q.start && cfg_q.en && cfg_q.armed) begin
                cfg_d.start = 1'b1;
            end
        end
        if (fill_done && !abort_d) begin
            cfg_d.start = 1'b0;
            cfg_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en_o    = cfg_q.en;
    assign start_o = cfg_q.start;
    assign armed_o = cfg_q.armed;
    assign pat_o   = cfg_q.pat;
    assign abort_o = abort_d;
endmodule

// File: rtl/cmi_seq.sv
module cmi_seq
    import cmi_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              kill,
    input  logic              frame_sync,
    output logic              busy_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o,
    output logic              all_written_o
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic              wr_done;
        logic              second;
    } seq_t;

    seq_t seq_d, seq_q;
    logic we_d, done_d;

    always_comb begin
        seq_d  = seq_q;
        we_d   = 1'b0;
        done_d = 1'b0;
        case (seq_q.state)
            SEQ_IDLE: begin
                if (go && !kill && frame_sync) begin
                    seq_d.state   = SEQ_FILL;
                    seq_d.addr    = '0;
                    seq_d.wr_done = 1'b0;
                    seq_d.second  = 1'b0;
                end
            end
            default: begin
                if (kill || !go) begin
                    seq_d.state = SEQ_IDLE;
                end else begin
                    we_d = !seq_q.wr_done;
                    if (we_d) begin
                        if (seq_q.addr == LAST_ADDR) begin
                            seq_d.wr_done = 1'b1;
                        end else begin
                            seq_d.addr = seq_q.addr + 1'b1;
                        end
                    end
                    if (frame_sync) begin
                        if (seq_q.second) begin
                            done_d      = 1'b1;
                            seq_d.state = SEQ_IDLE;
                        end else begin
                            seq_d.second = 1'b1;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: SEQ_IDLE, addr: '0, wr_done: 1'b0, second: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o        = (seq_q.state == SEQ_FILL);
    assign we_o          = we_d;
    assign addr_o        = seq_q.addr;
    assign done_o        = done_d;
    assign all_written_o = seq_q.wr_done;
endmodule

// File: rtl/cmi_mem.sv
module cmi_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = cells[raddr];
    end

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q;
endmodule

// File: rtl/cm_bulk_init.sv
module cm_bulk_init
    import cmi_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              cfg_we,
    input  logic              cfg_enable,
    input  logic              cfg_start,
    input  logic [2:0]        cfg_pattern,
    output logic              stat_enable,
    output logic              stat_start,
    output logic              stat_busy,
    input  logic              cm_we,
    input  logic [ADDR_W-1:0] cm_addr,
    input  logic [DATA_W-1:0] cm_wdata,
    output logic [DATA_W-1:0] cm_rdata
);
    localparam int PAD_W = DATA_W - PAT_W;

    logic             en_q, start_q, armed_q, abort;
    logic [PAT_W-1:0] pat_q;
    logic             fill_we, fill_done, fill_busy, all_written;
    logic [ADDR_W-1:0] fill_addr;
    logic             mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;

    cmi_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_enable  (cfg_enable),
        .cfg_start   (cfg_start),
        .cfg_pattern (cfg_pattern),
        .fill_done   (fill_done),
        .en_o        (en_q),
        .start_o     (start_q),
        .armed_o     (armed_q),
        .pat_o       (pat_q),
        .abort_o     (abort)
    );

    cmi_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .go            (start_q),
        .kill          (abort),
        .frame_sync    (frame_sync),
        .busy_o        (fill_busy),
        .we_o          (fill_we),
        .addr_o        (fill_addr),
        .done_o        (fill_done),
        .all_written_o (all_written)
    );

    always_comb begin
        mem_we    = fill_we | (cm_we & ~start_q);
        mem_addr  = fill_we ? fill_addr : cm_addr;
        mem_wdata = fill_we ? {{PAD_W{1'b0}}, pat_q} : cm_wdata;
    end

    cmi_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .raddr (cm_addr),
        .rdata (cm_rdata)
    );

    assign stat_enable = en_q;
    assign stat_start  = start_q;
    assign stat_busy   = fill_busy;
endmodule

// File: rtl/cm_bulk_init_chk.sv
module cm_bulk_init_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              cfg_enable,
    input logic              cfg_start,
    input logic              en_q,
    input logic              start_q,
    input logic              armed_q,
    input logic              busy,
    input logic              fill_we,
    input logic              fill_done,
    input logic              all_written,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata
);
    // R2: start can only rise when enable was high beforehand
    p_start_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_q) |-> $past(en_q) && $past(armed_q));

    // R8: host path never reaches the memory while start is set
    p_host_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && !fill_we) |-> !mem_we);

    // R5: fill writes carry zero upper bits
    p_fill_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |-> (mem_wdata[DATA_W-1:3] == '0));

    // R4: completion only after every address was written
    p_done_after_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> all_written);

    // R4: busy only while a start is pending
    p_busy_needs_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> start_q);

    // R6: enable drops only on an explicit write
    p_enable_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !(cfg_we && !cfg_enable)) |=> en_q);

    // R7: abort write clears start and busy next cycle
    p_abort_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && start_q && (!cfg_start || !cfg_enable)) |=> (!start_q && !busy));
endmodule

bind cm_bulk_init cm_bulk_init_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_enable  (cfg_enable),
    .cfg_start   (cfg_start),
    .en_q        (en_q),
    .start_q     (start_q),
    .armed_q     (armed_q),
    .busy        (fill_busy),
    .fill_we     (fill_we),
    .fill_done   (fill_done),
    .all_written (all_written),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata)
);

// File: tb/tb_cm_bulk_init.sv
`timescale 1ns/1ps
module tb_cm_bulk_init;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int FRAME  = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_sync = 1'b0;
    logic              cfg_we = 1'b0, cfg_enable = 1'b0, cfg_start = 1'b0;
    logic [2:0]        cfg_pattern = '0;
    logic              stat_enable, stat_start, stat_busy;
    logic              cm_we = 1'b0;
    logic [ADDR_W-1:0] cm_addr = '0;
    logic [DATA_W-1:0] cm_wdata = '0;
    logic [DATA_W-1:0] cm_rdata;

    int total = 0;
    int bad = 0;
    int fcnt = 0;

    always #2 clk = ~clk;

    cm_bulk_init #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .cfg_we(cfg_we), .cfg_enable(cfg_enable), .cfg_start(cfg_start),
        .cfg_pattern(cfg_pattern), .stat_enable(stat_enable),
        .stat_start(stat_start), .stat_busy(stat_busy),
        .cm_we(cm_we), .cm_addr(cm_addr), .cm_wdata(cm_wdata), .cm_rdata(cm_rdata)
    );

    always @(negedge clk) begin
        if (!rst_n) fcnt = 1;
        else fcnt = (fcnt == FRAME - 1) ? 0 : fcnt + 1;
        frame_sync = rst_n && (fcnt == 0);
    end

    function automatic logic [DATA_W-1:0] seed(input int a);
        return 16'hA500 ^ DATA_W'(a * 3);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic host_wr(input int a, input logic [DATA_W-1:0] d);
        cm_we = 1'b1; cm_addr = ADDR_W'(a); cm_wdata = d;
        @(negedge clk);
        cm_we = 1'b0;
    endtask

    task automatic host_rd(input int a, output logic [DATA_W-1:0] d);
        cm_addr = ADDR_W'(a);
        @(negedge clk);
        d = cm_rdata;
    endtask

    task automatic cfg(input logic e, input logic s, input logic [2:0] p);
        cfg_we = 1'b1; cfg_enable = e; cfg_start = s; cfg_pattern = p;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic preload();
        for (int a = 0; a < DEPTH; a++) host_wr(a, seed(a));
    endtask

    // count of locations differing from expectation: first k hold pattern
    task automatic sweep(input string req, input int k, input logic [2:0] p);
        logic [DATA_W-1:0] v, e;
        int errs = 0;
        for (int a = 0; a < DEPTH; a++) begin
            host_rd(a, v);
            e = (a < k) ? {13'b0, p} : seed(a);
            if (v !== e) begin
                errs++;
                chk(1'b0, req, $sformatf("addr %0d", a), int'(v), int'(e));
            end
        end
        chk(errs == 0, req, "sweep", errs, 0);
    endtask

    task automatic wait_busy(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 3 * FRAME && !seen; i++) begin
            if (stat_busy) seen = 1'b1;
            else @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 4);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] v;
        bit seen;
        int cnt;
        repeat (3) @(negedge clk);
        chk({stat_enable, stat_start, stat_busy} == 3'b000, "R1", "status in reset",
            {stat_enable, stat_start, stat_busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({stat_enable, stat_start, stat_busy} == 3'b000, "R1", "status after reset",
            {stat_enable, stat_start, stat_busy}, 0);

        // R9 / R8: plain host writes then read back
        preload();
        sweep("R9", 0, 3'd0);

        // R2: start without enable is ignored; host write still lands
        cfg(1'b0, 1'b1, 3'd5);
        chk(stat_start == 1'b0, "R2", "start without enable", stat_start, 0);
        host_wr(3, 16'h1234);
        host_rd(3, v);
        chk(v == 16'h1234, "R8", "host write when idle", v, 16'h1234);
        host_wr(3, seed(3));
        repeat (FRAME) @(negedge clk);
        chk(stat_busy == 1'b0, "R2", "no fill without enable", stat_busy, 0);

        // R4/R5/R6: full fill
        cfg(1'b1, 1'b0, 3'd5);
        cfg(1'b1, 1'b1, 3'd5);
        chk(stat_start == 1'b1, "R2", "start after arm", stat_start, 1);
        wait_busy(seen);
        chk(seen, "R4", "busy rose", seen, 1);
        cnt = 0;
        while (stat_busy && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == 2 * FRAME, "R4", "busy cycles", cnt, 2 * FRAME);
        chk(stat_start == 1'b0, "R6", "start self-clear", stat_start, 0);
        chk(stat_enable == 1'b1, "R6", "enable kept", stat_enable, 1);
        sweep("R5", DEPTH, 3'd5);

        // R3: restart without re-arming is ignored
        cfg(1'b1, 1'b1, 3'd2);
        chk(stat_start == 1'b0, "R3", "restart ignored", stat_start, 0);
        repeat (3 * FRAME) @(negedge clk);
        host_rd(7, v);
        chk(v == 16'd5, "R3", "contents untouched", v, 5);

        // R7 via start clear, with a blocked host write mid-fill (R8)
        preload();
        cfg(1'b0, 1'b0, 3'd0);
        cfg(1'b1, 1'b0, 3'd6);
        cfg(1'b1, 1'b1, 3'd6);
        wait_busy(seen);
        chk(seen, "R4", "busy rose run 2", seen, 1);
        repeat (10) @(negedge clk);
        host_wr(2, 16'hFFFF);
        repeat (8) @(negedge clk);
        cfg(1'b1, 1'b0, 3'd6);
        chk({stat_start, stat_busy} == 2'b00, "R7", "abort by start clear",
            {stat_start, stat_busy}, 0);
        sweep("R7", 19, 3'd6);

        // R7 via enable clear
        preload();
        cfg(1'b1, 1'b1, 3'd1);
        chk(stat_start == 1'b1, "R2", "restart after abort", stat_start, 1);
        wait_busy(seen);
        chk(seen, "R4", "busy rose run 3", seen, 1);
        repeat (7) @(negedge clk);
        cfg(1'b0, 1'b1, 3'd1);
        chk({stat_enable, stat_start, stat_busy} == 3'b000, "R7", "abort by enable clear",
            {stat_enable, stat_start, stat_busy}, 0);
        sweep("R7", 7, 3'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule